// File: doc/BRIEF.md
# Operand Effective Address Generator

This block computes operand addresses for an 8-bit processor with a 16-bit address space. For each request it takes an addressing-mode code, up to two operand bytes that followed the opcode, the 16-bit index pair H:X, the stack pointer, the program counter (already pointing past the instruction) and a branch-taken flag. From these it returns a primary effective address and, for the four move forms, a second (destination) address. Flags say whether each address names a memory operand. For the post-increment forms it also returns the incremented index pair.

Requests and results flow as streams with a valid/ready handshake and one register stage between them. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. A result transfers where `res_valid` and `res_ready` are both high. While a result waits with `res_ready` low, it stays held and unchanged and `req_ready` stays low, so back-pressure reaches the requester in the same cycle. When the result stage is empty, or is being drained in that cycle, a new request is accepted and appears at the output on the next cycle. Decoding opcodes, sequencing operand fetches and data-path arithmetic belong to other blocks.

Top module: `eag_top`

## Requirements
- R1: After reset `res_valid` is 0 and `req_ready` is 1. A request accepted at a clock edge shows as `res_valid`=1 after that edge, and `req_ready` is 1 whenever the result stage is empty or `res_ready` is 1.
- R2: Mode codes 0 (no operand) and 1 (immediate) give `res_ea`=0, `res_ea_use`=0, `res_dst`=0, `res_dst_use`=0 and leave H:X unchanged (`res_hx`=`req_hx`, `res_hx_upd`=0). These last three values also apply to every mode that R8 and R10 do not name.
- R3: Mode 2 (direct page) gives `res_ea` = {8'h00, op0} with `res_ea_use`=1.
- R4: Mode 3 (extended) gives `res_ea` = {op0, op1}, where op0 is the high byte, with `res_ea_use`=1.
- R5: Modes 4, 5 and 6 (indexed) give H:X, H:X + zero-extended op0, and H:X + {op0, op1}, each with `res_ea_use`=1. When H is 0 the mode 4 address equals X.
- R6: Modes 7 and 8 (stack relative) give SP + zero-extended op0 and SP + {op0, op1}, with `res_ea_use`=1.
- R7: Mode 9 (relative) gives `res_ea` = PC + sign-extended op0 when `req_taken`=1, and `res_ea` = PC when `req_taken`=0, with `res_ea_use`=0.
- R8: Modes 10 and 11 (post-increment) give `res_ea` = H:X or H:X + zero-extended op0, with `res_ea_use`=1. They also give `res_hx` = H:X + 1 with `res_hx_upd`=1.
- R9: Mode 12 (immediate to direct page) gives `res_ea_use`=0, `res_ea`=0 and `res_dst` = {8'h00, op1}. Mode 13 (direct page to direct page) gives `res_ea` = {8'h00, op0} and `res_dst` = {8'h00, op1}. Both modes set `res_dst_use`=1.
- R10: Mode 14 gives source `res_ea` = H:X and destination `res_dst` = {8'h00, op0}. Mode 15 gives source `res_ea` = {8'h00, op0} and destination `res_dst` = H:X. Both set both use flags, `res_hx` = H:X + 1 and `res_hx_upd`=1.
- R11: Every address sum and the H:X increment wrap modulo 2^16, and a carry out of X propagates into H.
- R12: While `res_valid`=1 and `res_ready`=0, all result outputs hold their values, `req_ready` is 0, and a request offered meanwhile is taken only after the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_mode | input | 4 | Addressing-mode code |
| req_op0 | input | 8 | First operand byte |
| req_op1 | input | 8 | Second operand byte |
| req_hx | input | 16 | Index pair H:X |
| req_sp | input | 16 | Stack pointer |
| req_pc | input | 16 | Program counter after the instruction |
| req_taken | input | 1 | Branch condition met (relative mode) |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_ea | output | 16 | Primary (source) address or branch target |
| res_ea_use | output | 1 | Primary address names a memory operand |
| res_dst | output | 16 | Destination address for move forms |
| res_dst_use | output | 1 | Destination address is in use |
| res_hx | output | 16 | Index pair after the instruction |
| res_hx_upd | output | 1 | Index pair was incremented |

## Verification
The assertions assume that the requester keeps the mode and operand inputs at legal codes whenever `req_valid` is high, and that the consumer's `res_ready` is a plain level that never depends on `req_valid`. Under these assumptions, the only result that pairs a post-increment with a high destination byte is the indexed-destination move. The stimulus drives only the sixteen defined mode codes and changes inputs only on the falling clock edge. It holds `res_ready` low only in one dedicated stall sequence. Every mode is swept against index, stack, program-counter and operand values that include both wrap points and the sign boundary of the relative offset.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [3:0] {
    AM_NONE   = 4'd0,
    AM_IMM    = 4'd1,
    AM_DP     = 4'd2,
    AM_ABS    = 4'd3,
    AM_X0     = 4'd4,
    AM_X8     = 4'd5,
    AM_X16    = 4'd6,
    AM_S8     = 4'd7,
    AM_S16    = 4'd8,
    AM_BRANCH = 4'd9,
    AM_XINC0  = 4'd10,
    AM_XINC8  = 4'd11,
    AM_MV_ID  = 4'd12,
    AM_MV_DD  = 4'd13,
    AM_MV_XD  = 4'd14,
    AM_MV_DX  = 4'd15
  } am_e;

  localparam int unsigned AM_W = 4;

endpackage

// File: rtl/eag_wrap_add.sv
module eag_wrap_add #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  // Carry out of the top bit is dropped: modulo 2^W.
  logic [W:0] full;
  always_comb begin
    full = {1'b0, a} + {1'b0, b};
    sum  = full[W-1:0];
  end
endmodule

// File: rtl/eag_calc.sv
module eag_calc
  import eag_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [AM_W-1:0]   mode,
  input  logic [BYTE_W-1:0] op0,
  input  logic [BYTE_W-1:0] op1,
  input  logic [ADDR_W-1:0] hx,
  input  logic [ADDR_W-1:0] sp,
  input  logic [ADDR_W-1:0] pc,
  input  logic              taken,
  output logic [ADDR_W-1:0] ea,
  output logic              ea_use,
  output logic [ADDR_W-1:0] dst,
  output logic              dst_use,
  output logic [ADDR_W-1:0] hx_out,
  output logic              hx_upd
);
  localparam int unsigned HI_W = ADDR_W - BYTE_W;

  am_e am;
  logic [ADDR_W-1:0] base, offs, idx_sum, rel_off, rel_sum, hx_inc, dp0, dp1;

  always_comb begin
    am   = am_e'(mode);
    dp0  = {{HI_W{1'b0}}, op0};
    dp1  = {{HI_W{1'b0}}, op1};
    base = (am == AM_S8 || am == AM_S16) ? sp : hx;
    unique case (am)
      AM_X8, AM_S8, AM_XINC8: offs = dp0;
      AM_X16, AM_S16:         offs = {op0, op1};
      default:                offs = '0;
    endcase
    rel_off = {{HI_W{op0[BYTE_W-1]}}, op0};
  end

  eag_wrap_add #(.W(ADDR_W)) u_idx (.a(base), .b(offs),    .sum(idx_sum));
  eag_wrap_add #(.W(ADDR_W)) u_rel (.a(pc),   .b(rel_off), .sum(rel_sum));
  eag_wrap_add #(.W(ADDR_W)) u_inc (.a(hx),   .b(ADDR_W'(1)), .sum(hx_inc));

  always_comb begin
    ea      = '0;
    ea_use  = 1'b0;
    dst     = '0;
    dst_use = 1'b0;
    hx_upd  = 1'b0;
    unique case (am)
      AM_NONE, AM_IMM: ;
      AM_DP:    begin ea = dp0;        ea_use = 1'b1; end
      AM_ABS:   begin ea = {op0, op1}; ea_use = 1'b1; end
      AM_X0, AM_X8, AM_X16, AM_S8, AM_S16:
                begin ea = idx_sum;    ea_use = 1'b1; end
      AM_BRANCH: ea = taken ? rel_sum : pc;
      AM_XINC0, AM_XINC8:
                begin ea = idx_sum; ea_use = 1'b1; hx_upd = 1'b1; end
      AM_MV_ID: begin dst = dp1; dst_use = 1'b1; end
      AM_MV_DD: begin ea = dp0; ea_use = 1'b1; dst = dp1; dst_use = 1'b1; end
      AM_MV_XD: begin
        ea = hx;  ea_use = 1'b1; dst = dp0; dst_use = 1'b1; hx_upd = 1'b1;
      end
      AM_MV_DX: begin
        ea = dp0; ea_use = 1'b1; dst = hx;  dst_use = 1'b1; hx_upd = 1'b1;
      end
      default: ;
    endcase
    hx_out = hx_upd ? hx_inc : hx;
  end
endmodule

// File: rtl/eag_pipe.sv
module eag_pipe #(
  parameter int unsigned W       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         full_q;
      logic [W-1:0] data_q;
      always_comb in_ready = !full_q || out_ready;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          full_q <= 1'b0;
          data_q <= '0;
        end else if (in_valid && in_ready) begin
          full_q <= 1'b1;
          data_q <= in_data;
        end else if (out_ready) begin
          full_q <= 1'b0;
        end
      end
      always_comb begin
        out_valid = full_q;
        out_data  = data_q;
      end
    end else begin : g_thru
      always_comb begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
      end
    end
  endgenerate
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BYTE_W  = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AM_W-1:0]   req_mode,
  input  logic [BYTE_W-1:0] req_op0,
  input  logic [BYTE_W-1:0] req_op1,
  input  logic [ADDR_W-1:0] req_hx,
  input  logic [ADDR_W-1:0] req_sp,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic              req_taken,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_ea,
  output logic              res_ea_use,
  output logic [ADDR_W-1:0] res_dst,
  output logic              res_dst_use,
  output logic [ADDR_W-1:0] res_hx,
  output logic              res_hx_upd
);
  localparam int unsigned RES_W = 3 * ADDR_W + 3;

  logic [ADDR_W-1:0] c_ea, c_dst, c_hx;
  logic              c_ea_use, c_dst_use, c_hx_upd;
  logic [RES_W-1:0]  c_pack, r_pack;

  eag_calc #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_calc (
    .mode(req_mode), .op0(req_op0), .op1(req_op1),
    .hx(req_hx), .sp(req_sp), .pc(req_pc), .taken(req_taken),
    .ea(c_ea), .ea_use(c_ea_use), .dst(c_dst), .dst_use(c_dst_use),
    .hx_out(c_hx), .hx_upd(c_hx_upd)
  );

  always_comb c_pack = {c_ea, c_ea_use, c_dst, c_dst_use, c_hx, c_hx_upd};

  eag_pipe #(.W(RES_W), .REG_OUT(REG_OUT)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(c_pack),
    .out_valid(res_valid), .out_ready(res_ready), .out_data(r_pack)
  );

  always_comb {res_ea, res_ea_use, res_dst, res_dst_use, res_hx, res_hx_upd} = r_pack;
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [ADDR_W-1:0] res_ea,
  input logic              res_ea_use,
  input logic [ADDR_W-1:0] res_dst,
  input logic              res_dst_use,
  input logic [ADDR_W-1:0] res_hx,
  input logic              res_hx_upd
);
  localparam int unsigned HB = ADDR_W / 2;

  // R9
  dp_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_dst_use && !res_hx_upd) |-> (res_dst[ADDR_W-1:HB] == '0));

  // R10
  mv_hx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_dst_use && res_hx_upd && (res_dst[ADDR_W-1:HB] != '0))
      |-> (res_hx == res_dst + ADDR_W'(1)));

  // R2
  hx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hx_upd) |-> res_ea_use);

  generate
    if (REG_OUT) begin : g_seq
      // R1
      accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> res_valid);
      // R1
      empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> req_ready);
      // R12
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=>
          (res_valid && $stable(res_ea) && $stable(res_dst) && $stable(res_hx)
           && $stable(res_ea_use) && $stable(res_dst_use) && $stable(res_hx_upd)));
      // R12
      stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |-> !req_ready);
    end
  endgenerate
endmodule

bind eag_top eag_chk #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) i_eag_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_ea(res_ea),
  .res_ea_use(res_ea_use), .res_dst(res_dst), .res_dst_use(res_dst_use),
  .res_hx(res_hx), .res_hx_upd(res_hx_upd)
);

// File: tb/test_eag_top.sv
`timescale 1ns/1ps
module test_eag_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_taken = 1'b0, res_ready = 1'b1;
  logic [3:0]  req_mode = '0;
  logic [7:0]  req_op0 = '0, req_op1 = '0;
  logic [15:0] req_hx = '0, req_sp = '0, req_pc = '0;
  logic        req_ready, res_valid, res_ea_use, res_dst_use, res_hx_upd;
  logic [15:0] res_ea, res_dst, res_hx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  eag_top i_eag_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_op0(req_op0), .req_op1(req_op1),
    .req_hx(req_hx), .req_sp(req_sp), .req_pc(req_pc), .req_taken(req_taken),
    .res_valid(res_valid), .res_ready(res_ready), .res_ea(res_ea),
    .res_ea_use(res_ea_use), .res_dst(res_dst), .res_dst_use(res_dst_use),
    .res_hx(res_hx), .res_hx_upd(res_hx_upd)
  );

  // Packed as {ea, ea_use, dst, dst_use, hx, hx_upd}
  function automatic logic [50:0] model(input logic [3:0] m, input logic [7:0] a,
      input logic [7:0] b, input logic [15:0] hx, input logic [15:0] sp,
      input logic [15:0] pc, input logic t);
    logic [15:0] ea, dst, nhx;
    logic eu, du, hu;
    ea = 16'h0; dst = 16'h0; eu = 0; du = 0; hu = 0;
    case (m)
      4'd2:  begin ea = {8'h00, a}; eu = 1; end
      4'd3:  begin ea = {a, b}; eu = 1; end
      4'd4:  begin ea = hx; eu = 1; end
      4'd5:  begin ea = 16'((32'(hx) + 32'(a)) % 65536); eu = 1; end
      4'd6:  begin ea = 16'((32'(hx) + 32'({a, b})) % 65536); eu = 1; end
      4'd7:  begin ea = 16'((32'(sp) + 32'(a)) % 65536); eu = 1; end
      4'd8:  begin ea = 16'((32'(sp) + 32'({a, b})) % 65536); eu = 1; end
      4'd9:  ea = t ? 16'((32'(pc) + 65536 + (a >= 8'd128 ? 32'(a) - 256 : 32'(a))) % 65536) : pc;
      4'd10: begin ea = hx; eu = 1; hu = 1; end
      4'd11: begin ea = 16'((32'(hx) + 32'(a)) % 65536); eu = 1; hu = 1; end
      4'd12: begin dst = {8'h00, b}; du = 1; end
      4'd13: begin ea = {8'h00, a}; eu = 1; dst = {8'h00, b}; du = 1; end
      4'd14: begin ea = hx; eu = 1; dst = {8'h00, a}; du = 1; hu = 1; end
      4'd15: begin ea = {8'h00, a}; eu = 1; dst = hx; du = 1; hu = 1; end
      default: ;
    endcase
    nhx = hu ? 16'((32'(hx) + 1) % 65536) : hx;
    return {ea, eu, dst, du, nhx, hu};
  endfunction

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd0, 4'd1:         return "R2";
      4'd2:               return "R3";
      4'd3:               return "R4";
      4'd4, 4'd5, 4'd6:   return "R5";
      4'd7, 4'd8:         return "R6";
      4'd9:               return "R7";
      4'd10, 4'd11:       return "R8";
      4'd12, 4'd13:       return "R9";
      default:            return "R10";
    endcase
  endfunction

  task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [50:0] got();
    return {res_ea, res_ea_use, res_dst, res_dst_use, res_hx, res_hx_upd};
  endfunction

  task automatic drive(input logic [3:0] m, input logic [7:0] a, input logic [7:0] b,
      input logic [15:0] hx, input logic [15:0] sp, input logic [15:0] pc, input logic t);
    req_mode = m; req_op0 = a; req_op1 = b; req_hx = hx;
    req_sp = sp; req_pc = pc; req_taken = t; req_valid = 1'b1;
  endtask

  logic [15:0] hxs [5] = '{16'h0000, 16'h00FF, 16'h12FF, 16'hFFFF, 16'h8000};
  logic [7:0]  o0s [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
  logic [7:0]  o1s [3] = '{8'h00, 8'h01, 8'hFF};
  logic [15:0] sps [2] = '{16'h00FF, 16'hFFF0};
  logic [15:0] pcs [3] = '{16'h1000, 16'h0005, 16'hFFF0};

  initial begin
    logic [50:0] e1, e2;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {62'b0, res_valid, req_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep every mode across boundary values (R2..R11)
    for (int m = 0; m < 16; m++)
      for (int h = 0; h < 5; h++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 3; b++)
            for (int t = 0; t < 2; t++) begin
              drive(4'(m), o0s[a], o1s[b], hxs[h], sps[(a + b) % 2], pcs[(h + a) % 3], 1'(t));
              e1 = model(4'(m), o0s[a], o1s[b], hxs[h], sps[(a + b) % 2], pcs[(h + a) % 3], 1'(t));
              @(negedge clk);
              req_valid = 1'b0;
              // R1: accepted request shows valid one edge later
              if (m == 0 && h == 0 && a == 0 && b == 0 && t == 0)
                check("R1 accept", {63'b0, res_valid}, 64'h1);
              check(req_of(4'(m)), {13'b0, got()}, {13'b0, e1});
              @(negedge clk);
            end

    // R11: carry from X into H and full wrap
    drive(4'd10, 8'h00, 8'h00, 16'h12FF, 16'h0, 16'h0, 1'b0);
    @(negedge clk); req_valid = 1'b0;
    check("R11 carry", {48'b0, res_hx}, 64'h1300);
    @(negedge clk);
    drive(4'd6, 8'h00, 8'h02, 16'hFFFF, 16'h0, 16'h0, 1'b0);
    @(negedge clk); req_valid = 1'b0;
    check("R11 wrap", {48'b0, res_ea}, 64'h0001);
    @(negedge clk);
    // R5: H zero gives X-only access
    drive(4'd4, 8'h00, 8'h00, 16'h0042, 16'h0, 16'h0, 1'b0);
    @(negedge clk); req_valid = 1'b0;
    check("R5 xonly", {48'b0, res_ea}, 64'h0042);
    @(negedge clk);

    // R12: back-pressure hold
    res_ready = 1'b0;
    drive(4'd3, 8'hAB, 8'hCD, 16'h0, 16'h0, 16'h0, 1'b0);
    e1 = model(4'd3, 8'hAB, 8'hCD, 16'h0, 16'h0, 16'h0, 1'b0);
    @(negedge clk);
    drive(4'd7, 8'h10, 8'h00, 16'h0, 16'h2000, 16'h0, 1'b0);
    e2 = model(4'd7, 8'h10, 8'h00, 16'h0, 16'h2000, 16'h0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      check("R12 hold", {13'b0, got()}, {13'b0, e1});
      check("R12 ready low", {62'b0, res_valid, req_ready}, 64'h2);
      @(negedge clk);
    end
    res_ready = 1'b1;
    check("R12 first", {13'b0, got()}, {13'b0, e1});
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 second", {12'b0, res_valid, got()}, {12'b0, 1'b1, e2});
    @(negedge clk);
    check("R1 drained", {62'b0, res_valid, req_ready}, 64'h1);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule